// File: doc/BRIEF.md
# CAN Fault Confinement State Tracker

This block follows the fault confinement standing of a single CAN node. Error and success strobes from the protocol engine move an 8-bit receive error counter and an 8-bit transmit error counter up and down. From those counters the block derives a warning flag, a passive flag and a bus-off flag. It presents the counters and flags in one 32-bit status word, together with an encoded fault state.

Each time the decoded state changes, the block raises a one-cycle event so that software learns about the transition. Entering bus-off also raises a one-cycle request to abort every pending transmission.

A node in bus-off stays there until software drops its reset-mode control bit. After that, the block watches a stream of sampled bus bits. It leaves bus-off once it has counted 128 idle conditions, where each idle condition is a run of 11 consecutive recessive bits. Both counters are cleared when it leaves. The return to error-active produces the same state-change event, and software uses that event to restart transmission.

Top module: `fc_tracker`

## Requirements
- R1: `statusWord` carries the receive counter in bits 7:0 and the transmit counter in bits 15:8. Bit 17 is the warning flag, bit 18 the passive flag and bit 19 the bus-off flag. Every other bit reads 0, and after reset the whole word is 0.
- R2: Outside bus-off, `rxErrStb` adds 1 to the receive counter, saturating at 255, and `txErrStb` adds 8 to the transmit counter. `rxOkStb` and `txOkStb` each subtract 1 from their own counter, stopping at 0. When an error strobe and a success strobe for the same counter arrive in the same cycle, only the error strobe takes effect.
- R3: Bit 17 is set while either counter is 96 or more. Bit 18 is set while either counter is 128 or more.
- R4: A transmit error that would carry the transmit counter beyond 255 enters bus-off. In that case the transmit counter holds 255 and bit 19 is set. While the node is in bus-off, all four counter strobes are ignored and both counters keep their values.
- R5: `faultState` encodes the state as 0 for error-active, 1 for warning, 2 for passive and 3 for bus-off. Precedence runs bus-off, then passive, then warning. `stateChange` is high for exactly the one cycle in which `faultState` first shows a new value.
- R6: `txAbortAll` is high for one cycle, in the same cycle that `faultState` first reads 3.
- R7: Bus-off recovery counts bits only while `resetMode` is 0. While `resetMode` is 1, all progress towards recovery is discarded.
- R8: During recovery, an idle condition is 11 consecutive samples with `bitValid`=1 and `busBit`=1 (recessive). A dominant sample (`busBit`=0) restarts the current run but keeps the number of idle conditions already completed.
- R9: When the 128th idle condition completes, the node leaves bus-off for error-active (`faultState`=0). Both counters become 0 and `stateChange` pulses. Counter strobes arriving in that completing cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resetMode | input | 1 | Software reset-mode control bit; recovery counting runs only while it is 0 |
| rxErrStb | input | 1 | Receive error detected |
| rxOkStb | input | 1 | Frame received successfully |
| txErrStb | input | 1 | Transmit error detected |
| txOkStb | input | 1 | Frame transmitted successfully |
| bitValid | input | 1 | `busBit` holds a new bus sample this cycle |
| busBit | input | 1 | Sampled bus level, 1 = recessive |
| statusWord | output | 32 | Counters and state flags |
| faultState | output | 2 | Encoded fault confinement state |
| stateChange | output | 1 | One-cycle pulse on every state transition |
| txAbortAll | output | 1 | One-cycle request to abort all pending transmissions on bus-off entry |

## Verification
Two functions can fall in the same cycle: completion of bus-off recovery by the final recessive bit, and counter strobes from the protocol engine. The bench provokes this directly. It steers recovery to within one bit of completion, including a dominant bit partway through the last run, and then asserts error strobes for both counters alongside the completing recessive sample. It judges the result by requiring counters of 0, state 0 and a single change pulse in the next sampled cycle. Random stimulus then repeats bus-off entries and recoveries with strobes active throughout, checked cycle by cycle against a bench model.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARNING = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fcState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdCounters;   // freeze counters (bus-off)
    logic runRecovery;    // count idle sequences
  } fcCtl_t;

  localparam int STAT_W        = 32;
  localparam int STAT_RX_LSB   = 0;
  localparam int STAT_TX_LSB   = 8;
  localparam int STAT_FIELD_W  = 8;
  localparam int STAT_WARN_BIT = 17;
  localparam int STAT_PASS_BIT = 18;
  localparam int STAT_BOFF_BIT = 19;

  function automatic fcState_e decodeState(input logic isBusOff,
                                           input logic isPassive,
                                           input logic isWarning);
    if (isBusOff)       return FC_BUSOFF;
    else if (isPassive) return FC_PASSIVE;
    else if (isWarning) return FC_WARNING;
    else                return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_ERR_STEP = 8,
  parameter int RX_ERR_STEP = 1,
  parameter int RUN_BITS    = 11,
  parameter int IDLE_COUNT  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcCtl_t           ctl,
  input  logic             rxErrStb,
  input  logic             rxOkStb,
  input  logic             txErrStb,
  input  logic             txOkStb,
  input  logic             bitValid,
  input  logic             busBit,
  output logic [CNT_W-1:0] rxCnt,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] nextRx,
  output logic [CNT_W-1:0] nextTx,
  output logic             txOverflow,
  output logic             recoveryDone
);

  localparam int              RUN_W   = $clog2(RUN_BITS);
  localparam int              IDLE_W  = $clog2(IDLE_COUNT);
  localparam logic [CNT_W:0]  CNT_MAX = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(RUN_BITS - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_COUNT - 1);

  logic [RUN_W-1:0]  runCnt, nextRun;
  logic [IDLE_W-1:0] idleCnt, nextIdle;
  logic [CNT_W:0]    txSum, rxSum;
  logic              runComplete;

  assign txSum = {1'b0, txCnt} + (CNT_W+1)'(TX_ERR_STEP);
  assign rxSum = {1'b0, rxCnt} + (CNT_W+1)'(RX_ERR_STEP);

  assign txOverflow  = !ctl.holdCounters && txErrStb && (txSum > CNT_MAX);
  assign runComplete = ctl.runRecovery && bitValid && busBit && (runCnt == RUN_LAST);
  assign recoveryDone = runComplete && (idleCnt == IDLE_LAST);

  // Counter arithmetic
  always_comb begin
    nextTx = txCnt;
    nextRx = rxCnt;
    if (recoveryDone) begin
      nextTx = '0;
      nextRx = '0;
    end else if (!ctl.holdCounters) begin
      if (txErrStb) begin
        nextTx = txOverflow ? CNT_MAX[CNT_W-1:0] : txSum[CNT_W-1:0];
      end else if (txOkStb && (txCnt != '0)) begin
        nextTx = txCnt - 1'b1;
      end
      if (rxErrStb) begin
        nextRx = (rxSum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : rxSum[CNT_W-1:0];
      end else if (rxOkStb && (rxCnt != '0)) begin
        nextRx = rxCnt - 1'b1;
      end
    end
  end

  // Idle sequence counting
  always_comb begin
    nextRun  = runCnt;
    nextIdle = idleCnt;
    if (!ctl.runRecovery || recoveryDone) begin
      nextRun  = '0;
      nextIdle = '0;
    end else if (bitValid) begin
      if (!busBit) begin
        nextRun = '0;
      end else if (runComplete) begin
        nextRun  = '0;
        nextIdle = idleCnt + 1'b1;
      end else begin
        nextRun = runCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt   <= '0;
      txCnt   <= '0;
      runCnt  <= '0;
      idleCnt <= '0;
    end else begin
      rxCnt   <= nextRx;
      txCnt   <= nextTx;
      runCnt  <= nextRun;
      idleCnt <= nextIdle;
    end
  end

  // R4
  hold_counters_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.holdCounters && !recoveryDone) |=> ($stable(rxCnt) && $stable(txCnt)));

  // R7
  recovery_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.runRecovery |=> (runCnt == '0 && idleCnt == '0));

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runRecovery && bitValid && !busBit) |=> (runCnt == '0 && $stable(idleCnt)));

  // R9
  clear_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    recoveryDone |=> (rxCnt == '0 && txCnt == '0));

endmodule

// File: rtl/fc_control.sv
module fc_control
  import fc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic [CNT_W-1:0] nextRx,
  input  logic [CNT_W-1:0] nextTx,
  input  logic             txOverflow,
  input  logic             recoveryDone,
  output fcCtl_t           ctl,
  output fcState_e         state,
  output logic             stateChange,
  output logic             txAbortAll
);

  fcState_e nextState;
  logic     nextWarn, nextPass;

  assign nextWarn = (32'(nextRx) >= WARN_LIM) || (32'(nextTx) >= WARN_LIM);
  assign nextPass = (32'(nextRx) >= PASS_LIM) || (32'(nextTx) >= PASS_LIM);

  assign ctl.holdCounters = (state == FC_BUSOFF);
  assign ctl.runRecovery  = (state == FC_BUSOFF) && !resetMode;

  always_comb begin
    if (state == FC_BUSOFF) begin
      nextState = recoveryDone ? FC_ACTIVE : FC_BUSOFF;
    end else begin
      nextState = decodeState(txOverflow, nextPass, nextWarn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= FC_ACTIVE;
      stateChange <= 1'b0;
      txAbortAll  <= 1'b0;
    end else begin
      state       <= nextState;
      stateChange <= (nextState != state);
      txAbortAll  <= (nextState == FC_BUSOFF) && (state != FC_BUSOFF);
    end
  end

  // R5
  change_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |-> stateChange);

  // R5
  change_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateChange |-> (state != $past(state)));

  // R6
  abort_on_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAbortAll |-> (state == FC_BUSOFF && stateChange));

  // R9
  busoff_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == FC_BUSOFF) |=> (state == FC_BUSOFF || state == FC_ACTIVE));

  // R7
  reset_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == FC_BUSOFF && resetMode) |=> (state == FC_BUSOFF));

endmodule

// File: rtl/fc_tracker.sv
module fc_tracker
  import fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASS_LIM    = 128,
  parameter int TX_ERR_STEP = 8,
  parameter int RX_ERR_STEP = 1,
  parameter int RUN_BITS    = 11,
  parameter int IDLE_COUNT  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        resetMode,
  input  logic        rxErrStb,
  input  logic        rxOkStb,
  input  logic        txErrStb,
  input  logic        txOkStb,
  input  logic        bitValid,
  input  logic        busBit,
  output logic [31:0] statusWord,
  output logic [1:0]  faultState,
  output logic        stateChange,
  output logic        txAbortAll
);

  fcCtl_t           ctl;
  fcState_e         state;
  logic [CNT_W-1:0] rxCnt, txCnt, nextRx, nextTx;
  logic             txOverflow, recoveryDone;

  fc_datapath #(
    .CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP), .RX_ERR_STEP(RX_ERR_STEP),
    .RUN_BITS(RUN_BITS), .IDLE_COUNT(IDLE_COUNT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rxErrStb(rxErrStb), .rxOkStb(rxOkStb),
    .txErrStb(txErrStb), .txOkStb(txOkStb),
    .bitValid(bitValid), .busBit(busBit),
    .rxCnt(rxCnt), .txCnt(txCnt), .nextRx(nextRx), .nextTx(nextTx),
    .txOverflow(txOverflow), .recoveryDone(recoveryDone)
  );

  fc_control #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) i_control (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .nextRx(nextRx), .nextTx(nextTx),
    .txOverflow(txOverflow), .recoveryDone(recoveryDone),
    .ctl(ctl), .state(state),
    .stateChange(stateChange), .txAbortAll(txAbortAll)
  );

  always_comb begin
    statusWord = '0;
    statusWord[STAT_RX_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(rxCnt);
    statusWord[STAT_TX_LSB +: STAT_FIELD_W] = STAT_FIELD_W'(txCnt);
    statusWord[STAT_WARN_BIT] = (32'(rxCnt) >= WARN_LIM) || (32'(txCnt) >= WARN_LIM);
    statusWord[STAT_PASS_BIT] = (32'(rxCnt) >= PASS_LIM) || (32'(txCnt) >= PASS_LIM);
    statusWord[STAT_BOFF_BIT] = (state == FC_BUSOFF);
  end

  assign faultState = state;

  // R3
  flag_nesting_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[STAT_PASS_BIT] |-> statusWord[STAT_WARN_BIT]);

endmodule

// File: tb/test_fc_tracker.sv
module test_fc_tracker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        resetMode, rxErrStb, rxOkStb, txErrStb, txOkStb, bitValid, busBit;
  logic [31:0] statusWord;
  logic [1:0]  faultState;
  logic        stateChange, txAbortAll;

  int checks = 0;
  int errors = 0;

  // Bench model
  int mRx, mTx, mRun, mIdle, mState;
  bit mBus;
  int expChange, expAbort;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_tracker i_fc_tracker (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .rxErrStb(rxErrStb), .rxOkStb(rxOkStb), .txErrStb(txErrStb), .txOkStb(txOkStb),
    .bitValid(bitValid), .busBit(busBit),
    .statusWord(statusWord), .faultState(faultState),
    .stateChange(stateChange), .txAbortAll(txAbortAll)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int decodeRef(input bit bo, input int rx, input int tx);
    if (bo) return 3;
    if (rx >= 128 || tx >= 128) return 2;
    if (rx >= 96 || tx >= 96) return 1;
    return 0;
  endfunction

  function automatic int statusRef(input bit bo, input int rx, input int tx);
    int s;
    s = rx | (tx << 8);
    if (rx >= 96 || tx >= 96) s |= (1 << 17);
    if (rx >= 128 || tx >= 128) s |= (1 << 18);
    if (bo) s |= (1 << 19);
    return s;
  endfunction

  task automatic modelStep(input bit rxE, rxO, txE, txO, rm, bv, bb);
    int oldState;
    oldState = mState;
    if (mBus) begin
      if (rm) begin
        mRun = 0; mIdle = 0;
      end else if (bv) begin
        if (!bb) mRun = 0;
        else if (mRun == 10) begin
          mRun = 0;
          if (mIdle == 127) begin
            mIdle = 0; mBus = 0; mRx = 0; mTx = 0;
          end else mIdle++;
        end else mRun++;
      end
    end else begin
      if (rxE) mRx = (mRx == 255) ? 255 : mRx + 1;
      else if (rxO && mRx > 0) mRx--;
      if (txE) begin
        if (mTx + 8 > 255) begin mBus = 1; mTx = 255; end
        else mTx += 8;
      end else if (txO && mTx > 0) mTx--;
      mRun = 0; mIdle = 0;
    end
    mState    = decodeRef(mBus, mRx, mTx);
    expChange = (mState != oldState) ? 1 : 0;
    expAbort  = (mState == 3 && oldState != 3) ? 1 : 0;
  endtask

  // Called at a falling edge; drives, clocks, compares at the next falling edge
  task automatic step(input bit rxE, rxO, txE, txO, rm, bv, bb);
    int expStat;
    rxErrStb = rxE; rxOkStb = rxO; txErrStb = txE; txOkStb = txO;
    resetMode = rm; bitValid = bv; busBit = bb;
    @(posedge clk);
    modelStep(rxE, rxO, txE, txO, rm, bv, bb);
    @(negedge clk);
    expStat = statusRef(mBus, mRx, mTx);
    chk("R2 rx counter", int'(statusWord[7:0]), mRx);
    chk("R2 tx counter", int'(statusWord[15:8]), mTx);
    chk("R3 warn/pass flags", int'(statusWord[18:17]), (expStat >> 17) & 3);
    chk("R4 bus-off flag", int'(statusWord[19]), (expStat >> 19) & 1);
    chk("R1 unused bits", int'({statusWord[31:20], statusWord[16]}), 0);
    chk("R5 faultState", int'(faultState), mState);
    chk("R5 stateChange", int'(stateChange), expChange);
    chk("R6 txAbortAll", int'(txAbortAll), expAbort);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit rmPhase;
    int txRate;
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    resetMode = 1'b1; rxErrStb = 0; rxOkStb = 0; txErrStb = 0; txOkStb = 0;
    bitValid = 0; busBit = 1;
    mRx = 0; mTx = 0; mRun = 0; mIdle = 0; mState = 0; mBus = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 reset statusWord", int'(statusWord), 0);
    chk("R5 reset faultState", int'(faultState), 0);
    chk("R5 reset stateChange", int'(stateChange), 0);

    // R3 warning via receive errors
    for (int i = 0; i < 96; i++) step(1, 0, 0, 0, 0, 0, 1);
    chk("R3 warning flag at rx=96", int'(statusWord[17]), 1);
    chk("R5 warning state", int'(faultState), 1);
    // R2 error beats success in one cycle
    step(1, 1, 0, 0, 0, 0, 1);
    chk("R2 err+ok gives rx=97", int'(statusWord[7:0]), 97);

    // R4 / R6 drive transmit counter into bus-off
    for (int i = 0; i < 31; i++) step(0, 0, 1, 0, 0, 0, 1);
    chk("R2 tx at 248", int'(statusWord[15:8]), 248);
    step(0, 0, 1, 0, 0, 0, 1);
    chk("R4 bus-off entered", int'(faultState), 3);
    chk("R6 abort pulse", int'(txAbortAll), 1);
    step(0, 1, 0, 1, 1, 0, 1);
    chk("R6 abort one cycle", int'(txAbortAll), 0);
    chk("R4 tx held at 255", int'(statusWord[15:8]), 255);
    chk("R4 rx held", int'(statusWord[7:0]), 97);

    // R7 reset mode blocks recovery
    for (int i = 0; i < 1500; i++) step(1, 0, 1, 0, 1, 1, 1);
    chk("R7 still bus-off in reset mode", int'(faultState), 3);

    // R8 / R9 recovery with a dominant bit in the last run
    for (int i = 0; i < 127 * 11 + 5; i++) step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 1);
    chk("R8 dominant restarts run only", int'(faultState), 3);
    step(1, 0, 1, 0, 0, 1, 1);
    chk("R9 recovered to active", int'(faultState), 0);
    chk("R9 counters cleared", int'(statusWord), 0);
    chk("R9 change pulse", int'(stateChange), 1);

    // Random phase
    rmPhase = 0;
    txRate = 6;
    for (int i = 0; i < 16000; i++) begin
      if (i % 500 == 0) begin
        rmPhase = (($urandom % 10) < 3);
        txRate  = (($urandom % 2) == 0) ? 6 : 40;
      end
      step(($urandom % 8) == 0, ($urandom % 4) == 0,
           ($urandom % txRate) == 0, ($urandom % 4) == 0,
           rmPhase, ($urandom % 4) != 0, ($urandom % 80) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule